// File: doc/BRIEF.md
# Shift-Add Transposed FIR Filter

This block is a single-rate FIR filter with coefficients fixed at elaboration. It uses no general multipliers. Each accepted input sample goes to every tap in the same cycle. One shared network builds all the coefficient products from shifts and adds. Each coefficient is split into signed power-of-two digits, and digit pairs that form three times a power of two draw on a single shared `3x` term. The shifted copies of `x` and `3x` are the partial products that every tap reuses.

The products feed a chain of delay-and-add registers. Each register holds a partial sum, not an old input sample. Tap `k` adds its product to the partial sum coming down from tap `k+1`. Because every adder is followed by a register, the path between registers is one product tree plus one adder, and the structure needs no extra pipeline stages.

Each stage register is only as wide as the number of products it has collected requires. The output carries the full precision with no rounding and no saturation. A sample is accepted only in a cycle with its valid strobe high. A result leaves the block one clock later, also with a valid strobe.

Top module: `tmcm_fir`

## Requirements
- R1: `outVld` equals `inVld` delayed by one clock. While `rstN` is low, `outVld` is 0 and `yOut` is 0.
- R2: Every tap product formed by the shift-add network equals the exact product of the input sample and that tap's coefficient, for every coefficient value, including the most negative one and zero.
- R3: For each accepted sample n, `yOut` equals the sum over k from 0 to NTAPS-1 of h(k)·x(n-k). Samples from before the last reset count as zero, and this covers the first NTAPS-1 outputs.
- R4: In a cycle with `inVld` low, no partial sum changes and `yOut` keeps its value. A later accepted sample continues the filter as if the idle cycles had never happened.
- R5: `yOut` is IN_W+COEF_W+ceil(log2(NTAPS)) bits wide, in two's complement. It never wraps, even for long runs of -2^(IN_W-1) or 2^(IN_W-1)-1 at the input.
- R6: After reset, a single sample of value 1 followed by zero-valued samples gives the outputs h(0), h(1), …, h(NTAPS-1), in that order.
- R7: Asserting `rstN` low in the middle of a stream clears every partial sum. The first sample after release then gives h(0)·x.
- R8: The result for a sample accepted at clock edge t is present on `yOut`, with `outVld` high, right after edge t. The latency is one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inVld | input | 1 | High when `inSample` holds a sample to accept |
| inSample | input | IN_W | Signed input sample |
| outVld | output | 1 | High when `yOut` holds the result of a sample just accepted |
| yOut | output | IN_W+COEF_W+ceil(log2(NTAPS)) | Signed full-precision filter output |

## Verification
The assertions take for granted that `inSample` and `inVld` are known at every rising clock edge while reset is released. The per-tap product check also assumes that `inSample` is held steady across the sampling edge. The bench changes these inputs only on falling edges. It also holds `inVld` low throughout reset, so the one-cycle valid relation starts from a clean state. Idle gaps, full-scale runs and mid-stream resets are all driven through the same two input ports, and a direct-form model in the bench follows them in parallel.

// File: rtl/tmcm_fir_pkg.sv
package tmcm_fir_pkg;

  localparam int MAX_TAPS = 64;
  localparam int MAX_CW   = 24;
  localparam int PACK_W   = MAX_TAPS * MAX_CW;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;
  } firStrobes_t;

  typedef enum logic [2:0] {
    TERM_NONE,
    TERM_POS1,
    TERM_NEG1,
    TERM_POS3,
    TERM_NEG3
  } termKind_t;

  // Signed-digit recoding of coef. A digit pair (+s at b+2, -s at b) is
  // merged into one 3x term of sign s at b. Returns the term at pos.
  function automatic termKind_t csdTerm(longint coef, int width, int pos);
    int dig [MAX_CW+3];
    longint v;
    longint m;
    v = coef;
    for (int b = 0; b < MAX_CW + 3; b++) dig[b] = 0;
    for (int b = 0; b <= width; b++) begin
      if (v % 2 != 0) begin
        m = ((v % 4) + 4) % 4;
        dig[b] = (m == 1) ? 1 : -1;
        v = v - longint'(dig[b]);
      end
      v = v / 2;
    end
    for (int b = 0; b + 2 <= width; b++) begin
      if (dig[b] != 0 && dig[b+1] == 0 && dig[b+2] == -dig[b]) begin
        dig[b]   = 3 * dig[b+2];
        dig[b+2] = 0;
      end
    end
    case (dig[pos])
      1:       return TERM_POS1;
      -1:      return TERM_NEG1;
      3:       return TERM_POS3;
      -3:      return TERM_NEG3;
      default: return TERM_NONE;
    endcase
  endfunction

  // Default coefficient set, packed with tap 0 in the low bits.
  function automatic logic [PACK_W-1:0] defaultCoefs(int taps, int width);
    logic [PACK_W-1:0] packedSet;
    logic [63:0] masked;
    longint val;
    packedSet = '0;
    for (int k = 0; k < taps; k++) begin
      if (k == 0)      val = -(longint'(1) <<< (width - 1));
      else if (k == 1) val = (longint'(1) <<< (width - 1)) - 1;
      else if (k == 3) val = 0;
      else             val = longint'(((k * 2749 + 1013) % 4001) - 2000);
      masked = 64'(val) & ((64'd1 << width) - 64'd1);
      packedSet = packedSet | (PACK_W'(masked) << (k * width));
    end
    return packedSet;
  endfunction

endpackage

// File: rtl/tmcm_fir_mcm.sv
module tmcm_fir_mcm #(
  parameter int IN_W   = 16,
  parameter int COEF_W = 16,
  parameter int NTAPS  = 32,
  parameter int PROD_W = IN_W + COEF_W,
  parameter logic [NTAPS*COEF_W-1:0] COEFS = '0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [IN_W-1:0]   sample,
  output logic signed [PROD_W-1:0] prods [NTAPS]
);
  import tmcm_fir_pkg::*;

  localparam int DIGITS = COEF_W + 1;

  // shared fundamentals: x and 3x, and every shift of them
  logic signed [PROD_W-1:0] oneX;
  logic signed [PROD_W-1:0] threeX;
  logic signed [PROD_W-1:0] shOne   [DIGITS];
  logic signed [PROD_W-1:0] shThree [DIGITS];

  assign oneX   = PROD_W'(sample);
  assign threeX = oneX + (oneX <<< 1);

  for (genvar b = 0; b < DIGITS; b++) begin : g_shift
    assign shOne[b]   = oneX <<< b;
    assign shThree[b] = threeX <<< b;
  end

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    localparam longint CVAL = longint'($signed(COEFS[k*COEF_W +: COEF_W]));
    logic signed [PROD_W-1:0] terms [DIGITS];
    logic signed [PROD_W-1:0] tapSum;

    for (genvar b = 0; b < DIGITS; b++) begin : g_dig
      localparam termKind_t KIND = csdTerm(CVAL, COEF_W, b);
      if (KIND == TERM_POS1) begin : g_p1
        assign terms[b] = shOne[b];
      end else if (KIND == TERM_NEG1) begin : g_n1
        assign terms[b] = -shOne[b];
      end else if (KIND == TERM_POS3) begin : g_p3
        assign terms[b] = shThree[b];
      end else if (KIND == TERM_NEG3) begin : g_n3
        assign terms[b] = -shThree[b];
      end else begin : g_z
        assign terms[b] = '0;
      end
    end

    always_comb begin
      tapSum = '0;
      for (int b = 0; b < DIGITS; b++) tapSum = tapSum + terms[b];
    end

    assign prods[k] = tapSum;

    // R2: the shift-add tree matches a true multiply
    a_r2_exact_product: assert property (@(posedge clk) disable iff (!rstN)
      tapSum == PROD_W'(longint'(sample) * CVAL));
  end

endmodule

// File: rtl/tmcm_fir_chain.sv
module tmcm_fir_chain #(
  parameter int NTAPS  = 32,
  parameter int PROD_W = 32,
  parameter int ACC_W  = PROD_W + $clog2(NTAPS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  tmcm_fir_pkg::firStrobes_t     strobes,
  input  logic signed [PROD_W-1:0]      prods [NTAPS],
  output logic signed [ACC_W-1:0]       yOut
);

  // sign-extended view of each stage register
  logic signed [ACC_W-1:0] carry [NTAPS];

  for (genvar i = 0; i < NTAPS; i++) begin : g_stage
    localparam int SW = PROD_W + $clog2(NTAPS - i);
    logic signed [SW-1:0] partial;
    logic signed [SW-1:0] nextVal;

    if (i == NTAPS - 1) begin : g_head
      assign nextVal = SW'(prods[i]);
    end else begin : g_link
      assign nextVal = SW'(prods[i]) + SW'(carry[i+1]);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                partial <= '0;
      else if (strobes.advance) partial <= nextVal;
    end

    assign carry[i] = ACC_W'(partial);
  end

  assign yOut = carry[0];

  // R3: the highest tap loads its own product on every accepted sample
  a_r3_head_loads_product: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |=> carry[NTAPS-1] == ACC_W'($past(prods[NTAPS-1])));

  // R4: the stage feeding the output holds while idle
  a_r4_chain_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.advance |=> $stable(carry[1 % NTAPS]));

endmodule

// File: rtl/tmcm_fir_ctl.sv
module tmcm_fir_ctl (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inVld,
  output tmcm_fir_pkg::firStrobes_t strobes,
  output logic                      outVld
);

  assign strobes.advance = inVld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outVld <= 1'b0;
    else       outVld <= inVld;
  end

  // R1: valid out is valid in one clock later
  a_r1_valid_delay: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> outVld == $past(inVld));

endmodule

// File: rtl/tmcm_fir.sv
module tmcm_fir #(
  parameter int NTAPS  = 32,
  parameter int IN_W   = 16,
  parameter int COEF_W = 16,
  parameter logic [NTAPS*COEF_W-1:0] COEFS =
    (NTAPS*COEF_W)'(tmcm_fir_pkg::defaultCoefs(NTAPS, COEF_W))
) (
  input  logic                                            clk,
  input  logic                                            rstN,
  input  logic                                            inVld,
  input  logic signed [IN_W-1:0]                          inSample,
  output logic                                            outVld,
  output logic signed [IN_W+COEF_W+$clog2(NTAPS)-1:0]     yOut
);

  localparam int PROD_W = IN_W + COEF_W;
  localparam int ACC_W  = PROD_W + $clog2(NTAPS);

  tmcm_fir_pkg::firStrobes_t strobes;
  logic signed [PROD_W-1:0] prods [NTAPS];

  tmcm_fir_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .inVld   (inVld),
    .strobes (strobes),
    .outVld  (outVld)
  );

  tmcm_fir_mcm #(
    .IN_W   (IN_W),
    .COEF_W (COEF_W),
    .NTAPS  (NTAPS),
    .PROD_W (PROD_W),
    .COEFS  (COEFS)
  ) u_mcm (
    .clk    (clk),
    .rstN   (rstN),
    .sample (inSample),
    .prods  (prods)
  );

  tmcm_fir_chain #(
    .NTAPS  (NTAPS),
    .PROD_W (PROD_W),
    .ACC_W  (ACC_W)
  ) u_chain (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .prods   (prods),
    .yOut    (yOut)
  );

  // R4: output holds across idle cycles
  a_r4_output_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inVld |=> $stable(yOut));

endmodule

// File: tb/tb_tmcm_fir.sv
`timescale 1ns/1ps
module tb_tmcm_fir;

  localparam int NT = 32;
  localparam int IW = 16;
  localparam int CW = 16;
  localparam int AW = IW + CW + $clog2(NT);

  localparam logic signed [CW-1:0] TB_COEFS [NT] = '{
    -16'sd32768, 16'sd32767, 16'sd0, 16'sd1, -16'sd1, 16'sd3, -16'sd3, 16'sd5,
    -16'sd5, 16'sd7, 16'sd21845, -16'sd21846, 16'sd12345, -16'sd12345, 16'sd255, -16'sd256,
    16'sd1000, -16'sd999, 16'sd4095, -16'sd4096, 16'sd17, -16'sd17, 16'sd96, -16'sd96,
    16'sd2047, 16'sd30000, -16'sd30000, 16'sd11, 16'sd13, -16'sd1234, 16'sd5461, 16'sd8
  };

  function automatic logic [NT*CW-1:0] packCoefs();
    logic [NT*CW-1:0] p;
    for (int k = 0; k < NT; k++) p[k*CW +: CW] = TB_COEFS[k];
    return p;
  endfunction

  localparam logic [NT*CW-1:0] PACKED = packCoefs();

  typedef struct packed {
    logic             vld;
    logic signed [IW-1:0] smp;
  } stim_t;

  localparam int NSTIM = 20;
  localparam stim_t STIM [NSTIM] = '{
    '{1'b1, 16'sd100},    '{1'b1, -16'sd7},     '{1'b0, 16'sd999},   '{1'b1, 16'sd32767},
    '{1'b0, -16'sd5},     '{1'b0, 16'sd0},      '{1'b1, -16'sd32768}, '{1'b1, 16'sd1},
    '{1'b1, 16'sd2},      '{1'b0, 16'sd12345},  '{1'b1, -16'sd3},    '{1'b1, 16'sd4660},
    '{1'b1, -16'sd21555}, '{1'b0, 16'sd77},     '{1'b1, 16'sd0},     '{1'b1, 16'sd17},
    '{1'b1, 16'sd30000},  '{1'b0, -16'sd1},     '{1'b1, -16'sd2},    '{1'b1, 16'sd8191}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inVld = 1'b0;
  logic signed [IW-1:0] inSample = '0;
  logic outVld;
  logic signed [AW-1:0] yOut;

  int checks = 0;
  int errors = 0;
  longint hist [NT];
  longint lastExp = 0;

  always #2 clk = ~clk;

  tmcm_fir #(.NTAPS(NT), .IN_W(IW), .COEF_W(CW), .COEFS(PACKED)) dut (
    .clk(clk), .rstN(rstN), .inVld(inVld), .inSample(inSample),
    .outVld(outVld), .yOut(yOut)
  );

  function automatic longint refDot();
    longint acc = 0;
    for (int k = 0; k < NT; k++) acc += longint'(TB_COEFS[k]) * hist[k];
    return acc;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearModel();
    for (int k = 0; k < NT; k++) hist[k] = 0;
    lastExp = 0;
  endtask

  task automatic step(string tag, logic v, logic signed [IW-1:0] x);
    @(negedge clk);
    inVld = v;
    inSample = x;
    @(posedge clk);
    #1;
    if (v) begin
      for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = longint'(x);
      lastExp = refDot();
    end
    check({tag, " outVld"}, longint'(outVld), longint'(v));
    check({tag, " yOut"}, longint'(yOut), lastExp);
  endtask

  task automatic doReset(string tag);
    @(negedge clk);
    rstN = 1'b0;
    inVld = 1'b0;
    @(posedge clk);
    #1;
    check({tag, " reset outVld"}, longint'(outVld), 0);
    check({tag, " reset yOut"}, longint'(yOut), 0);
    clearModel();
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(4ns * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    clearModel();
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset outVld", longint'(outVld), 0);
    check("R1 reset yOut", longint'(yOut), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R6: unit impulse gives the coefficients in order
    step("R6 impulse", 1'b1, 16'sd1);
    for (int k = 1; k < NT; k++) step("R6 impulse", 1'b1, 16'sd0);

    // R2: scaled impulse exercises every tap product, R8 latency on first
    doReset("R7");
    step("R8 first sample", 1'b1, -16'sd12345);
    for (int k = 1; k < NT; k++) step("R2 scaled impulse", 1'b1, 16'sd0);

    // R3/R4: table walk with idle gaps
    for (int i = 0; i < NSTIM; i++) step("R3 R4 table", STIM[i].vld, STIM[i].smp);

    // R5: full-scale runs
    for (int i = 0; i < 40; i++) step("R5 min run", 1'b1, -16'sd32768);
    for (int i = 0; i < 40; i++) step("R5 max run", 1'b1, 16'sd32767);
    for (int i = 0; i < 40; i++) step("R5 alternating", 1'b1, (i % 2 == 0) ? -16'sd32768 : 16'sd32767);

    // R7: reset mid-stream then one sample gives h(0)*x
    doReset("R7");
    step("R7 after reset", 1'b1, 16'sd321);
    check("R7 first result", longint'(yOut), longint'(TB_COEFS[0]) * 321);

    // R3: pseudo-random stream with random idle cycles
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step("R3 random", lfsr[17:16] != 2'b00, lfsr[15:0]);
    end

    @(negedge clk);
    inVld = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule